// File: doc/BRIEF.md
# Capture/Auto-Reload 16-bit Timer

This block is a 16-bit up-counter paired with a 16-bit capture/reload register and steered by an 8-bit control register. The counter advances either on a free-running tick input or on falling edges of an external count pin. An external trigger pin can do one of two things on a falling edge. It can latch the running count into the capture/reload register, or it can force the counter to load from that register. The counter can also reload from the register each time it overflows.

Two clock-enable bits turn the block into a baud generator. While either is set, the mode bit is overridden so that every overflow reloads the counter. The sticky overflow flag stays quiet in this mode. Each overflow is also emitted as a single-cycle pulse that a serial port can use as its bit clock.

Software reaches the control register, the counter and the capture/reload register through one small select/write/read port. An interrupt request is formed from the two sticky flags, an interrupt enable input and a down-count-mode input.

Top module: `cap_reload_timer16`

## Requirements
- R1: After reset the control register, the counter and the capture/reload register all read 0, and `irq` and `baud_pulse` are 0.
- R2: `sel` = 0 addresses the control register (low 8 bits), 1 the counter and 2 the capture/reload register. `sel` = 3 reads 0. A write with `wr_en` = 1 is visible from the next cycle. Control bit positions, from 7 down to 0: overflow flag, external flag, receive-clock enable, transmit-clock enable, external enable, run, count-source select, capture-mode select.
- R3: The overflow flag (bit 7) is set when the counter steps from FFFFH. It is not set while bit 5 or bit 4 is 1. It stays set until software writes the control register.
- R4: With the run bit (bit 2) at 0 the counter holds its value.
- R5: With bit 1 at 0 the counter advances once per cycle in which `tick` is 1. With bit 1 at 1 it advances once per falling edge of `cnt_pin`. That edge takes effect on the third rising clock edge after the pin falls.
- R6: When bit 0 is 0, or bit 5 or bit 4 is 1, an overflow loads the counter from the capture/reload register.
- R7: In capture mode (bit 0 = 1 with bits 5 and 4 at 0), an overflow wraps the counter to 0. A trigger falling edge with bit 3 = 1 copies the counter into the capture/reload register.
- R8: With bit 0 = 0, bits 5 and 4 at 0 and bit 3 = 1, a trigger falling edge loads the counter from the capture/reload register.
- R9: A trigger falling edge with bit 3 = 1 sets the external flag (bit 6), which stays set until software writes it. With bit 3 = 0 a trigger edge changes neither flag nor registers.
- R10: Every overflow gives `baud_pulse` = 1 for exactly the one cycle following the overflow edge.
- R11: `irq` is 1 exactly when `irq_en` is 1 and either the overflow flag is set, or the external flag is set while `dcen` is 0.
- R12: A software write to a register takes priority over a hardware update of that register in the same cycle (flag set, count, reload).
- R13: With bit 5 or bit 4 at 1, a trigger falling edge with bit 3 = 1 sets the external flag but neither captures nor reloads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Internal count enable |
| cnt_pin | input | 1 | Asynchronous external count input |
| trig_pin | input | 1 | Asynchronous external trigger input |
| irq_en | input | 1 | Interrupt enable |
| dcen | input | 1 | Down-count mode enabled; masks the external flag from `irq` |
| wr_en | input | 1 | Register write strobe |
| sel | input | 2 | Register select |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data for `sel` |
| ovf_flag | output | 1 | Sticky overflow flag |
| ext_flag | output | 1 | Sticky external-trigger flag |
| irq | output | 1 | Interrupt request |
| baud_pulse | output | 1 | One-cycle pulse per overflow |

## Verification
Each internal register can be read back directly. A corrupted count or capture value is therefore visible on `rdata` in the cycle after it occurs. A wrong reload or wrap shows up one edge after the overflow, alongside `baud_pulse`. A wrong flag state reaches `irq`, `ovf_flag` and `ext_flag` in the cycle after the offending edge. A wrong pin-synchronizer depth would move the count or trigger effect by a whole cycle, so the bench samples the count exactly on both sides of the expected edge.

// File: rtl/crt_pkg.sv
package crt_pkg;

   localparam int unsigned CTL_W = 8;

   // control word, most significant field first
   typedef struct packed {
      logic ovf;    // bit 7 sticky overflow flag
      logic ext;    // bit 6 sticky external flag
      logic rxck;   // bit 5 receive clock enable
      logic txck;   // bit 4 transmit clock enable
      logic exen;   // bit 3 trigger enable
      logic run;    // bit 2 run
      logic csel;   // bit 1 count source: 1 = pin edges
      logic capm;   // bit 0 capture mode select
   } ctl_t;

   typedef enum logic [1:0] {
      SEL_CTL  = 2'd0,
      SEL_CNT  = 2'd1,
      SEL_CAP  = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/crt_fall_det.sv
module crt_fall_det #(
   parameter int STAGES = 2
)(
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic fall
);
   logic [STAGES-1:0] sync_q;
   logic              last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], pin};
         last_q <= sync_q[STAGES-1];
      end
   end

   assign fall = last_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/crt_ctl_reg.sv
module crt_ctl_reg
   import crt_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CTL_W-1:0] wdata,
   input  logic             ovf_set,
   input  logic             ext_set,
   output ctl_t             ctl
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl <= '0;
      end else if (wr) begin
         ctl <= ctl_t'(wdata);
      end else begin
         if (ovf_set) ctl.ovf <= 1'b1;
         if (ext_set) ctl.ext <= 1'b1;
      end
   end
endmodule

// File: rtl/crt_core.sv
module crt_core #(
   parameter int W = 16
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cnt_wr,
   input  logic         cap_wr,
   input  logic [W-1:0] wdata,
   input  logic         count_en,
   input  logic         cap_active,
   input  logic         trig_hw,
   output logic [W-1:0] cnt_q,
   output logic [W-1:0] cap_q,
   output logic         ovf_evt,
   output logic         baud_pulse
);
   logic [W-1:0] cnt_d, cap_d;

   assign ovf_evt = count_en && (cnt_q == '1);

   always_comb begin
      if (cnt_wr)                       cnt_d = wdata;
      else if (ovf_evt)                 cnt_d = cap_active ? '0 : cap_q;
      else if (trig_hw && !cap_active)  cnt_d = cap_q;
      else if (count_en)                cnt_d = cnt_q + W'(1);
      else                              cnt_d = cnt_q;
   end

   always_comb begin
      if (cap_wr)                       cap_d = wdata;
      else if (trig_hw && cap_active)   cap_d = cnt_q;
      else                              cap_d = cap_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         cap_q      <= '0;
         baud_pulse <= 1'b0;
      end else begin
         cnt_q      <= cnt_d;
         cap_q      <= cap_d;
         baud_pulse <= ovf_evt;
      end
   end
endmodule

// File: rtl/cap_reload_timer16.sv
module cap_reload_timer16
   import crt_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             cnt_pin,
   input  logic             trig_pin,
   input  logic             irq_en,
   input  logic             dcen,
   input  logic             wr_en,
   input  logic [1:0]       sel,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] rdata,
   output logic             ovf_flag,
   output logic             ext_flag,
   output logic             irq,
   output logic             baud_pulse
);
   localparam int NPIN    = 2;
   localparam int PIN_CNT = 0;
   localparam int PIN_TRG = 1;

   generate
      if (CNT_W < int'(CTL_W)) begin : g_bad_width
         $error("CNT_W must be at least the control word width");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [NPIN-1:0] pins, falls;
   assign pins = {trig_pin, cnt_pin};

   for (genvar gi = 0; gi < NPIN; gi++) begin : g_pin
      crt_fall_det #(.STAGES(SYNC_STAGES)) u_det (
         .clk  (clk),
         .rst_n(rst_n),
         .pin  (pins[gi]),
         .fall (falls[gi])
      );
   end

   ctl_t         ctl_q;
   logic [CNT_W-1:0] cnt_q, cap_q;
   logic baud_mode, count_en, trig_seen, trig_hw, cap_active, ovf_evt;
   logic ctl_wr, cnt_wr, cap_wr;

   assign ctl_wr     = wr_en && (sel == SEL_CTL);
   assign cnt_wr     = wr_en && (sel == SEL_CNT);
   assign cap_wr     = wr_en && (sel == SEL_CAP);
   assign baud_mode  = ctl_q.rxck || ctl_q.txck;
   assign cap_active = ctl_q.capm && !baud_mode;
   assign count_en   = ctl_q.run && (ctl_q.csel ? falls[PIN_CNT] : tick);
   assign trig_seen  = ctl_q.exen && falls[PIN_TRG];
   assign trig_hw    = trig_seen && !baud_mode;

   crt_ctl_reg u_ctl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (ctl_wr),
      .wdata  (wdata[CTL_W-1:0]),
      .ovf_set(ovf_evt && !baud_mode),
      .ext_set(trig_seen),
      .ctl    (ctl_q)
   );

   crt_core #(.W(CNT_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .cnt_wr    (cnt_wr),
      .cap_wr    (cap_wr),
      .wdata     (wdata),
      .count_en  (count_en),
      .cap_active(cap_active),
      .trig_hw   (trig_hw),
      .cnt_q     (cnt_q),
      .cap_q     (cap_q),
      .ovf_evt   (ovf_evt),
      .baud_pulse(baud_pulse)
   );

   always_comb begin
      rdata = '0;
      unique case (sel)
         SEL_CTL: rdata[CTL_W-1:0] = ctl_q;
         SEL_CNT: rdata = cnt_q;
         SEL_CAP: rdata = cap_q;
         default: rdata = '0;
      endcase
   end

   assign ovf_flag = ctl_q.ovf;
   assign ext_flag = ctl_q.ext;
   assign irq      = irq_en && (ctl_q.ovf || (ctl_q.ext && !dcen));
endmodule

// File: rtl/crt_checker.sv
module crt_checker #(
   parameter int W = 16
)(
   input logic         clk,
   input logic         rst_n,
   input logic [7:0]   ctl,
   input logic [W-1:0] cnt,
   input logic [W-1:0] cap,
   input logic         wr_en,
   input logic [1:0]   sel,
   input logic         baud_pulse,
   input logic         irq,
   input logic         irq_en
);
   // R3: no hardware change of the overflow flag while a clock enable is set
   p_flag_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!(wr_en && sel == 2'd0) && (ctl[5] || ctl[4])) |=> ctl[7] == $past(ctl[7]));

   // R4: stopped and trigger-disabled counter stays put without writes
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl[2] && !ctl[3] && !wr_en) |=> $stable(cnt));

   // R9: trigger disabled leaves capture register and external flag alone
   p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl[3] && !wr_en) |=> ($stable(cap) && ctl[6] == $past(ctl[6])));

   // R6: in baud mode each overflow pulse follows a reload
   p_baud_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (baud_pulse && $past(ctl[5] || ctl[4]) && !$past(wr_en)) |-> cnt == $past(cap));

   // R11: no request without enable, request whenever the overflow flag is enabled
   p_irq_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq);
   p_irq_ovf_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en && ctl[7]) |-> irq);
endmodule

bind cap_reload_timer16 crt_checker #(.W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ctl       (ctl_q),
   .cnt       (cnt_q),
   .cap       (cap_q),
   .wr_en     (wr_en),
   .sel       (sel),
   .baud_pulse(baud_pulse),
   .irq       (irq),
   .irq_en    (irq_en)
);

// File: tb/tb_cap_reload_timer16.sv
module tb_cap_reload_timer16;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0, cnt_pin = 1'b1, trig_pin = 1'b1;
   logic irq_en = 1'b0, dcen = 1'b0, wr_en = 1'b0;
   logic [1:0] sel = 2'd0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic ovf_flag, ext_flag, irq, baud_pulse;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   cap_reload_timer16 dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_pin(cnt_pin), .trig_pin(trig_pin),
      .irq_en(irq_en), .dcen(dcen), .wr_en(wr_en), .sel(sel), .wdata(wdata),
      .rdata(rdata), .ovf_flag(ovf_flag), .ext_flag(ext_flag), .irq(irq),
      .baud_pulse(baud_pulse)
   );

   typedef struct packed {
      logic [15:0] cnt0;
      logic [15:0] cap0;
      logic [7:0]  ctl;
      logic [7:0]  ticks;
      logic [15:0] exp_cnt;
      logic        exp_ovf;
   } vec_t;

   localparam int NVEC = 7;
   localparam vec_t VECS [NVEC] = '{
      '{16'h0010, 16'h0000, 8'h04, 8'd5, 16'h0015, 1'b0},  // R5 tick counting
      '{16'hFFFE, 16'h1234, 8'h04, 8'd3, 16'h1235, 1'b1},  // R6 reload on overflow, R3 flag
      '{16'hFFFE, 16'h1234, 8'h05, 8'd3, 16'h0001, 1'b1},  // R7 wrap in capture mode
      '{16'hFFFF, 16'hAAAA, 8'h34, 8'd2, 16'hAAAB, 1'b0},  // R3 no flag in baud mode
      '{16'hFFFF, 16'h5555, 8'h35, 8'd1, 16'h5555, 1'b0},  // R6 baud overrides capture mode
      '{16'h0100, 16'h0000, 8'h00, 8'd4, 16'h0100, 1'b0},  // R4 run off holds
      '{16'h0100, 16'h0000, 8'h06, 8'd4, 16'h0100, 1'b0}   // R5 pin source, no pin edges
   };

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] s, input logic [15:0] d);
      @(negedge clk);
      sel = s; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] s, output logic [15:0] v);
      sel = s;
      #1;
      v = rdata;
   endtask

   task automatic wait_neg(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic setup(input logic [15:0] c, input logic [15:0] p, input logic [7:0] ctl);
      wr(2'd0, 16'h0000);
      wr(2'd2, p);
      wr(2'd1, c);
      wr(2'd0, {8'h00, ctl});
   endtask

   task automatic trig_fall();
      @(negedge clk); trig_pin = 1'b0;
      wait_neg(4);
      trig_pin = 1'b1;
      wait_neg(4);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [15:0] v;
      wait_neg(3);
      rst_n = 1'b1;
      wait_neg(3);

      // R1 reset state
      rd(2'd0, v); chk("R1 ctl", v, 16'h0000);
      rd(2'd1, v); chk("R1 cnt", v, 16'h0000);
      rd(2'd2, v); chk("R1 cap", v, 16'h0000);
      chk("R1 irq/baud", {14'd0, irq, baud_pulse}, 16'h0000);

      // R2 write/readback and unused select
      wr(2'd2, 16'hBEEF);
      rd(2'd2, v); chk("R2 cap write", v, 16'hBEEF);
      rd(2'd3, v); chk("R2 sel3 reads 0", v, 16'h0000);

      // vector table
      for (int k = 0; k < NVEC; k++) begin
         setup(VECS[k].cnt0, VECS[k].cap0, VECS[k].ctl);
         for (int i = 0; i < int'(VECS[k].ticks); i++) begin
            @(negedge clk); tick = 1'b1;
         end
         @(negedge clk); tick = 1'b0;
         rd(2'd1, v); chk($sformatf("R3 R4 R5 R6 R7 vec%0d cnt", k), v, VECS[k].exp_cnt);
         rd(2'd2, v); chk($sformatf("R7 vec%0d cap kept", k), v, VECS[k].cap0);
         rd(2'd0, v);
         chk($sformatf("R3 vec%0d ctl", k), v, {8'h00, VECS[k].exp_ovf, VECS[k].ctl[6:0]});
      end

      // R5 pin edge latency and counting
      setup(16'h0000, 16'h0000, 8'h06);
      @(negedge clk); cnt_pin = 1'b0;
      wait_neg(2);
      rd(2'd1, v); chk("R5 no count before third edge", v, 16'h0000);
      wait_neg(1);
      rd(2'd1, v); chk("R5 count on third edge", v, 16'h0001);
      wait_neg(3); cnt_pin = 1'b1; wait_neg(4);
      for (int i = 0; i < 2; i++) begin
         cnt_pin = 1'b0; wait_neg(4); cnt_pin = 1'b1; wait_neg(4);
      end
      rd(2'd1, v); chk("R5 three pin edges", v, 16'h0003);

      // R7 capture on trigger
      setup(16'h4321, 16'h0000, 8'h09);
      trig_fall();
      rd(2'd2, v); chk("R7 captured count", v, 16'h4321);
      rd(2'd1, v); chk("R7 counter unchanged", v, 16'h4321);
      rd(2'd0, v); chk("R9 ext flag set", v, 16'h0049);

      // R8 reload on trigger
      setup(16'h0003, 16'h7777, 8'h08);
      trig_fall();
      rd(2'd1, v); chk("R8 trigger reload", v, 16'h7777);

      // R9 trigger ignored with enable off
      setup(16'h0050, 16'h0060, 8'h01);
      trig_fall();
      rd(2'd2, v); chk("R9 cap untouched", v, 16'h0060);
      rd(2'd1, v); chk("R9 cnt untouched", v, 16'h0050);
      rd(2'd0, v); chk("R9 no ext flag", v, 16'h0001);

      // R13 baud mode trigger: flag only
      setup(16'h0100, 16'h0200, 8'h38);
      trig_fall();
      rd(2'd1, v); chk("R13 cnt kept", v, 16'h0100);
      rd(2'd2, v); chk("R13 cap kept", v, 16'h0200);
      chk("R13 ext flag", {15'd0, ext_flag}, 16'h0001);

      // R11 interrupt combination (ext flag set, ovf clear)
      #1; chk("R11 irq masked", {15'd0, irq}, 16'h0000);
      irq_en = 1'b1; #1; chk("R11 irq from ext", {15'd0, irq}, 16'h0001);
      dcen = 1'b1; #1;   chk("R11 dcen masks ext", {15'd0, irq}, 16'h0000);
      wr(2'd0, 16'h0080); #1;
      chk("R11 irq from ovf", {15'd0, irq}, 16'h0001);
      chk("R3 ovf_flag port", {15'd0, ovf_flag}, 16'h0001);
      irq_en = 1'b0; dcen = 1'b0;

      // R10 baud pulse timing
      setup(16'hFFFF, 16'h0010, 8'h04);
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      chk("R10 pulse after overflow", {15'd0, baud_pulse}, 16'h0001);
      rd(2'd1, v); chk("R6 reloaded", v, 16'h0010);
      @(negedge clk);
      chk("R10 pulse one cycle", {15'd0, baud_pulse}, 16'h0000);
      chk("R3 flag sticky", {15'd0, ovf_flag}, 16'h0001);
      wr(2'd0, 16'h0004);
      chk("R3 flag cleared by write", {15'd0, ovf_flag}, 16'h0000);

      // R12 software write beats hardware flag set and count
      wr(2'd1, 16'hFFFF);
      @(negedge clk); sel = 2'd0; wdata = 16'h0004; wr_en = 1'b1; tick = 1'b1;
      @(negedge clk); wr_en = 1'b0; tick = 1'b0;
      rd(2'd0, v); chk("R12 flag write wins", v, 16'h0004);
      rd(2'd1, v); chk("R12 reload still done", v, 16'h0010);
      @(negedge clk); sel = 2'd1; wdata = 16'h1234; wr_en = 1'b1; tick = 1'b1;
      @(negedge clk); wr_en = 1'b0; tick = 1'b0;
      rd(2'd1, v); chk("R12 count write wins", v, 16'h1234);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule